// File: doc/BRIEF.md
# Serial Receiver Frame Synchronizer

This block sits between a serial line and a transparent bit-stream receiver and decides from which bit onwards the received bits are handed on as data. It runs on the bit clock: one `rx_bit` is sampled on every rising edge. Once it is in frame, it delivers each sampled bit one edge later on `out_bit`, qualified by `out_valid`.

Frame start comes from one of two sources, chosen by the two-bit `sync_len` field. In pattern mode the block hunts the incoming stream for an 8-bit or 16-bit pattern taken from `sync_pattern`. The bit after the last pattern bit is the first data bit, and the pattern bits are never delivered. In external mode the block instead waits for the carrier-detect input `cd_in`. That input is either sampled directly as a synchronous signal or passed through a two-flop synchronizer as an asynchronous signal. It is either a pulse, which starts an endless stream, or an envelope, which frames the data for as long as it stays high.

Top module: `rx_frame_sync`

## Requirements
- R1: While `rst_n` is low and after its release, `in_frame`, `out_valid` and `out_bit` are 0 until a frame starts.
- R2: The `sync_len` codes are: 2'b00 for external carrier detect, 2'b10 for an 8-bit pattern and 2'b11 for a 16-bit pattern. The reserved code 2'b01 behaves exactly like 2'b10.
- R3: In 8-bit mode, the pattern is `sync_pattern[7:0]`, with bit 0 received first and bit 7 received last. `in_frame` rises after the edge that samples the last pattern bit. The pattern bits themselves never appear with `out_valid` high.
- R4: In 16-bit mode, the pattern is `sync_pattern[15:0]`, with bit 0 (the first byte) received first and bit 15 received last. A match of the first byte alone does not start a frame.
- R5: A match counts only if every pattern bit was sampled after the hunt started. Bits still held from before a restart cannot complete a pattern.
- R6: While in frame, each sampled `rx_bit` appears on `out_bit` with `out_valid` high one edge after it is sampled. `out_bit` is 0 whenever `out_valid` is 0.
- R7: In external mode with synchronous sampling (`cd_async`=0), an edge that samples `cd_in` high while hunting makes `in_frame` rise after that same edge.
- R8: With asynchronous sampling (`cd_async`=1), the same start happens exactly two edges later than in R7.
- R9: In pulse mode (`cd_envelope`=0), a frame started by carrier detect continues when `cd_in` falls.
- R10: In envelope mode (`cd_envelope`=1), an edge that sees the qualified carrier low ends the frame. The bit sampled at that edge is not delivered. A later high level starts a new frame.
- R11: An edge that samples `enable` low returns the block to the hunt. `in_frame` and `out_valid` become 0, and the hunt restarts from scratch.
- R12: An edge at which the mode, the pattern length, `cd_envelope` or `cd_async` differs from its value at the previous edge returns the block to a fresh hunt at that edge.
- R13: In pattern mode, a frame ends only through R11 or R12. `cd_in` and further occurrences of the pattern do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, rising edge samples `rx_bit` |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Receiver enable; low forces the hunt |
| sync_len | input | 2 | Sync source and length: 00 external, 10 8-bit, 11 16-bit, 01 as 10 |
| sync_pattern | input | 16 | Pattern, bit 0 received first |
| cd_envelope | input | 1 | 1 = envelope carrier detect, 0 = pulse |
| cd_async | input | 1 | 1 = carrier detect passes the two-flop synchronizer |
| cd_in | input | 1 | Carrier-detect line |
| rx_bit | input | 1 | Serial data bit |
| in_frame | output | 1 | High while the block is in frame |
| out_valid | output | 1 | `out_bit` carries a delivered data bit |
| out_bit | output | 1 | Delivered data bit |

## Verification
`in_frame` follows its cause after one rising edge: the last pattern bit, a synchronous carrier sample, an enable drop or a configuration change. With asynchronous carrier sampling it follows after three edges. Each delivered bit shows on `out_bit` one edge after it is sampled, so `out_valid` trails `in_frame` by one edge. The bench drives inputs and samples the outputs on the falling edge. After each rising edge it steps a behavioural model that keeps the bits received since the hunt began in a queue, and it compares all three outputs against that model at the falling edge. Directed checks at the exact edge count confirm each start, hold and stop.

// File: rtl/rfs_pkg.sv
// Shared types for the receive frame synchronizer.
// Assumes sync_len codes: 00 external, 01 reserved (acts as 10), 10 short, 11 long.
package rfs_pkg;

    typedef enum logic [1:0] {
        SL_EXTERNAL = 2'b00,
        SL_RESERVED = 2'b01,
        SL_SHORT    = 2'b10,
        SL_LONG     = 2'b11
    } sync_len_e;

    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_FRAME = 1'b1
    } frame_state_e;

    // True when the code selects carrier-detect framing.
    function automatic logic is_external(input logic [1:0] code);
        return code == SL_EXTERNAL;
    endfunction

    // True when the code selects the full-width pattern.
    function automatic logic is_long(input logic [1:0] code);
        return code == SL_LONG;
    endfunction

endpackage

// File: rtl/rfs_cd_qualifier.sv
// Carrier-detect qualifier: picks either the raw line (synchronous sampling)
// or the output of a STAGES-deep flop chain (asynchronous sampling).
// Assumes STAGES >= 1; the chain runs continuously so switching is glitch-free
// apart from the restart the frame controller applies on any config change.
module rfs_cd_qualifier #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cd_in,
    input  logic use_chain,
    output logic cd_q
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single stage capture of the carrier line.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= cd_in;
            end
        end else begin : g_multi
            // Shift the carrier line through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], cd_in};
            end
        end
    endgenerate

    // Select the qualified carrier seen by the frame controller.
    always_comb begin
        cd_q = use_chain ? chain_q[STAGES-1] : cd_in;
    end

endmodule

// File: rtl/rfs_pattern_hunter.sv
// Pattern hunter: keeps the last PAT_W received bits (first received bit at
// index 0 of a full window) and flags a match on the edge that samples the
// last pattern bit. A saturating counter of bits seen since the last clear
// blocks matches on bits that predate the hunt.
// Assumes PAT_W is even; the short pattern is the low half of the pattern.
module rfs_pattern_hunter #(
    parameter int PAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             active,
    input  logic             long_mode,
    input  logic             rx_bit,
    input  logic [PAT_W-1:0] pattern,
    output logic             match
);

    localparam int SHORT_W = PAT_W / 2;
    localparam int CNT_W   = $clog2(PAT_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(PAT_W);
    localparam logic [CNT_W-1:0] SHORT_CNT = CNT_W'(SHORT_W);

    logic [PAT_W-1:0] window_q, window_d;
    logic [CNT_W-1:0] seen_q, seen_inc, need_cnt;
    logic             short_hit, long_hit, enough;

    // Window after the current bit enters at the top.
    always_comb begin
        window_d = {rx_bit, window_q[PAT_W-1:1]};
    end

    // Bit count including the current bit, saturating at the full width.
    always_comb begin
        seen_inc = (seen_q == FULL_CNT) ? seen_q : seen_q + 1'b1;
        need_cnt = long_mode ? FULL_CNT : SHORT_CNT;
        enough   = (seen_inc >= need_cnt);
    end

    // Compare the newest bits against the selected pattern length.
    always_comb begin
        short_hit = (window_d[PAT_W-1 -: SHORT_W] == pattern[SHORT_W-1:0]);
        long_hit  = (window_d == pattern);
        match     = active && enough && (long_mode ? long_hit : short_hit);
    end

    // Shift the window on every bit; count bits only while hunting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            window_q <= '0;
            seen_q   <= '0;
        end else begin
            window_q <= window_d;
            if (clear)       seen_q <= '0;
            else if (active) seen_q <= seen_inc;
        end
    end

endmodule

// File: rtl/rfs_frame_ctrl.sv
// Frame controller: two-state hunt/frame machine. Starts a frame on a pattern
// match or on the qualified carrier, ends it on enable loss, on any change of
// configuration, or on carrier loss in envelope mode. Delivers each in-frame
// bit one edge after sampling it.
// Assumes match is only raised while hunt_active is high.
module rfs_frame_ctrl
    import rfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ext_mode,
    input  logic long_mode,
    input  logic envelope,
    input  logic async_sel,
    input  logic cd_q,
    input  logic match,
    input  logic rx_bit,
    output logic in_frame,
    output logic out_valid,
    output logic out_bit,
    output logic hunt_clear,
    output logic hunt_active
);

    localparam int CFG_W = 4;

    logic [CFG_W-1:0] cfg_now, cfg_q;
    logic             cfg_change, deliver;
    frame_state_e     state_q, state_d;

    // Detect any configuration change since the previous edge.
    always_comb begin
        cfg_now    = {ext_mode, long_mode, envelope, async_sel};
        cfg_change = (cfg_now != cfg_q);
    end

    // Next-state decision for hunt and frame.
    always_comb begin
        state_d = state_q;
        if (!enable || cfg_change) begin
            state_d = ST_HUNT;
        end else if (state_q == ST_HUNT) begin
            if (ext_mode ? cd_q : match) state_d = ST_FRAME;
        end else if (ext_mode && envelope && !cd_q) begin
            state_d = ST_HUNT;
        end
    end

    // Hunter control and delivery qualification.
    always_comb begin
        hunt_active = enable && !cfg_change && !ext_mode && (state_q == ST_HUNT);
        hunt_clear  = !enable || cfg_change ||
                      ((state_q == ST_FRAME) && (state_d == ST_HUNT));
        deliver     = (state_q == ST_FRAME) && (state_d == ST_FRAME);
        in_frame    = (state_q == ST_FRAME);
    end

    // State, configuration history and delivered bit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            state_q   <= ST_HUNT;
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
        end else begin
            cfg_q     <= cfg_now;
            state_q   <= state_d;
            out_valid <= deliver;
            out_bit   <= deliver & rx_bit;
        end
    end

endmodule

// File: rtl/rx_frame_sync.sv
// Receive frame synchronizer top: decodes the sync-length code and joins the
// carrier qualifier, the pattern hunter and the frame controller.
// Assumes all inputs except cd_in are synchronous to clk.
module rx_frame_sync
    import rfs_pkg::*;
#(
    parameter int PAT_W     = 16,
    parameter int CD_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       sync_len,
    input  logic [PAT_W-1:0] sync_pattern,
    input  logic             cd_envelope,
    input  logic             cd_async,
    input  logic             cd_in,
    input  logic             rx_bit,
    output logic             in_frame,
    output logic             out_valid,
    output logic             out_bit
);

    logic ext_mode, long_mode, cd_q, match, hunt_clear, hunt_active;

    // Decode the sync source and pattern length.
    always_comb begin
        ext_mode  = is_external(sync_len);
        long_mode = is_long(sync_len);
    end

    rfs_cd_qualifier #(
        .STAGES (CD_STAGES)
    ) u_cd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cd_in     (cd_in),
        .use_chain (cd_async),
        .cd_q      (cd_q)
    );

    rfs_pattern_hunter #(
        .PAT_W (PAT_W)
    ) u_hunt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (hunt_clear),
        .active    (hunt_active),
        .long_mode (long_mode),
        .rx_bit    (rx_bit),
        .pattern   (sync_pattern),
        .match     (match)
    );

    rfs_frame_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .ext_mode    (ext_mode),
        .long_mode   (long_mode),
        .envelope    (cd_envelope),
        .async_sel   (cd_async),
        .cd_q        (cd_q),
        .match       (match),
        .rx_bit      (rx_bit),
        .in_frame    (in_frame),
        .out_valid   (out_valid),
        .out_bit     (out_bit),
        .hunt_clear  (hunt_clear),
        .hunt_active (hunt_active)
    );

endmodule

// File: rtl/rx_frame_sync_checker.sv
// Port-level properties of the frame synchronizer, bound to every instance.
module rx_frame_sync_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic [1:0] sync_len,
    input logic       cd_envelope,
    input logic       cd_async,
    input logic       cd_in,
    input logic       rx_bit,
    input logic       in_frame,
    input logic       out_valid,
    input logic       out_bit
);

    // R6: delivered bits only while in frame for two consecutive edges
    assert_valid_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (in_frame && $past(in_frame)));

    // R6: the delivered bit is the one sampled at the previous edge
    assert_bit_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_bit == $past(rx_bit)));

    // R6: idle data is zero
    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_bit);

    // R11: enable low forces the hunt
    assert_enable_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!in_frame && !out_valid));

    // R7: synchronous carrier starts the frame after one edge
    assert_ext_sync_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sync_len == 2'b00 && !cd_async && cd_in && !in_frame &&
         $past(rst_n) && $stable(sync_len) && $stable(cd_envelope) && $stable(cd_async))
        |=> in_frame);

    // R10: envelope carrier loss ends the frame
    assert_envelope_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && enable && sync_len == 2'b00 && cd_envelope && !cd_async && !cd_in)
        |=> !in_frame);

    // R9: pulse mode frame survives carrier loss
    assert_pulse_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && enable && sync_len == 2'b00 && !cd_envelope && $past(rst_n) &&
         $stable(sync_len) && $stable(cd_envelope) && $stable(cd_async))
        |=> in_frame);

endmodule

bind rx_frame_sync rx_frame_sync_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .sync_len    (sync_len),
    .cd_envelope (cd_envelope),
    .cd_async    (cd_async),
    .cd_in       (cd_in),
    .rx_bit      (rx_bit),
    .in_frame    (in_frame),
    .out_valid   (out_valid),
    .out_bit     (out_bit)
);

// File: tb/rx_frame_sync_test.sv
`timescale 1ns/1ps
module rx_frame_sync_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  sync_len = 2'b10;
    logic [15:0] sync_pattern = 16'hA5C3;
    logic        cd_envelope = 1'b0;
    logic        cd_async = 1'b0;
    logic        cd_in = 1'b0;
    logic        rx_bit = 1'b0;
    logic        in_frame, out_valid, out_bit;

    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Behavioural model state
    bit    m_frame, m_valid, m_bit;
    bit    m_sync [$];
    bit    m_hist [$];
    bit [3:0] m_cfg_prev;

    always #2 clk = ~clk;

    rx_frame_sync uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .sync_len     (sync_len),
        .sync_pattern (sync_pattern),
        .cd_envelope  (cd_envelope),
        .cd_async     (cd_async),
        .cd_in        (cd_in),
        .rx_bit       (rx_bit),
        .in_frame     (in_frame),
        .out_valid    (out_valid),
        .out_bit      (out_bit)
    );

    // One rising edge of the model, using the inputs held across it.
    task automatic model_step();
        bit ext, lng, cd_seen, nxt, hit;
        bit [3:0] cfg;
        int len;
        if (!rst_n) begin
            m_frame = 0; m_valid = 0; m_bit = 0; m_cfg_prev = 0;
            m_sync = '{0, 0}; m_hist.delete();
            return;
        end
        ext = (sync_len == 2'b00);
        lng = (sync_len == 2'b11);
        cfg = {ext, lng, cd_envelope, cd_async};
        cd_seen = cd_async ? m_sync[0] : cd_in;
        void'(m_sync.pop_front());
        m_sync.push_back(cd_in);
        nxt = m_frame;
        if (!enable || cfg != m_cfg_prev) begin
            nxt = 0;
            m_hist.delete();
        end else if (!m_frame) begin
            if (ext) nxt = cd_seen;
            else begin
                m_hist.push_back(rx_bit);
                if (m_hist.size() > 16) void'(m_hist.pop_front());
                len = lng ? 16 : 8;
                hit = (m_hist.size() >= len);
                for (int i = 0; i < len; i++)
                    if (hit && m_hist[m_hist.size() - len + i] != sync_pattern[i]) hit = 0;
                nxt = hit;
            end
        end else if (ext && cd_envelope && !cd_seen) begin
            nxt = 0;
            m_hist.delete();
        end
        m_cfg_prev = cfg;
        m_valid = m_frame && nxt;
        m_bit   = m_valid && rx_bit;
        m_frame = nxt;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one bit, clock it, then compare against the model at the falling edge.
    task automatic tick(input bit b, input bit c);
        rx_bit = b;
        cd_in  = c;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check({in_frame, out_valid, out_bit} === {m_frame, m_valid, m_bit}, cur_req,
              "frame/valid/bit", {in_frame, out_valid, out_bit}, {m_frame, m_valid, m_bit});
    endtask

    task automatic send_bits(input logic [15:0] v, input int first, input int last);
        for (int i = first; i <= last; i++) tick(v[i], 1'b0);
    endtask

    task automatic restart_with(input logic [1:0] sl, input bit env, input bit asy);
        enable = 0;
        tick(1'b0, 1'b0);
        sync_len = sl; cd_envelope = env; cd_async = asy;
        tick(1'b0, 1'b0);
        enable = 1;
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        tick(1'b1, 1'b1);
        tick(1'b1, 1'b1);
        check(!in_frame && !out_valid && !out_bit, "R1", "outputs in reset",
              {in_frame, out_valid, out_bit}, 0);
        rst_n = 1;
        tick(1'b0, 1'b0);
        check(!in_frame && !out_valid, "R1", "after release", in_frame, 0);

        // R3: 8-bit pattern, low byte 0xC3, bit 0 first
        cur_req = "R3";
        restart_with(2'b10, 0, 0);
        repeat (5) tick(1'b0, 1'b0);
        send_bits(sync_pattern, 0, 6);
        check(in_frame == 0, "R3", "one bit before pattern end", in_frame, 0);
        send_bits(sync_pattern, 7, 7);
        check(in_frame == 1, "R3", "frame after last pattern bit", in_frame, 1);
        check(out_valid == 0, "R3", "pattern bit not delivered", out_valid, 0);
        tick(1'b1, 1'b0);
        check(out_valid == 1 && out_bit == 1, "R6", "first data bit", {out_valid, out_bit}, 3);
        tick(1'b0, 1'b0);
        check(out_valid == 1 && out_bit == 0, "R6", "second data bit", {out_valid, out_bit}, 2);

        // R2: reserved code acts as 8-bit
        cur_req = "R2";
        restart_with(2'b01, 0, 0);
        send_bits(sync_pattern, 0, 7);
        check(in_frame == 1, "R2", "reserved code hunts 8-bit", in_frame, 1);

        // R4: 16-bit pattern 0xA5C3, first byte alone must not start
        cur_req = "R4";
        restart_with(2'b11, 0, 0);
        repeat (3) tick(1'b0, 1'b0);
        send_bits(sync_pattern, 0, 7);
        check(in_frame == 0, "R4", "first byte alone", in_frame, 0);
        send_bits(sync_pattern, 8, 14);
        check(in_frame == 0, "R4", "one bit short", in_frame, 0);
        send_bits(sync_pattern, 15, 15);
        check(in_frame == 1, "R4", "full 16-bit match", in_frame, 1);

        // R5: pattern split by a restart must not match
        cur_req = "R5";
        restart_with(2'b10, 0, 0);
        send_bits(sync_pattern, 0, 4);
        enable = 0;
        send_bits(sync_pattern, 5, 5);
        enable = 1;
        send_bits(sync_pattern, 6, 7);
        check(in_frame == 0, "R5", "stale bits ignored", in_frame, 0);
        send_bits(sync_pattern, 0, 7);
        check(in_frame == 1, "R5", "fresh full pattern", in_frame, 1);

        // R13: pattern frame ignores carrier and repeated patterns
        cur_req = "R13";
        tick(1'b1, 1'b1);
        tick(1'b0, 1'b0);
        send_bits(sync_pattern, 0, 7);
        check(in_frame == 1 && out_valid == 1, "R13", "frame persists", {in_frame, out_valid}, 3);

        // R7 and R9: synchronous pulse carrier
        cur_req = "R7";
        restart_with(2'b00, 0, 0);
        tick(1'b1, 1'b0);
        check(in_frame == 0, "R7", "no carrier", in_frame, 0);
        tick(1'b1, 1'b1);
        check(in_frame == 1, "R7", "frame one edge after carrier", in_frame, 1);
        cur_req = "R9";
        repeat (5) tick(1'b1, 1'b0);
        check(in_frame == 1 && out_valid == 1, "R9", "pulse frame holds", {in_frame, out_valid}, 3);

        // R8: asynchronous carrier adds two edges
        cur_req = "R8";
        restart_with(2'b00, 0, 1);
        repeat (3) tick(1'b0, 1'b0);
        tick(1'b0, 1'b1);
        check(in_frame == 0, "R8", "edge 1", in_frame, 0);
        tick(1'b0, 1'b0);
        check(in_frame == 0, "R8", "edge 2", in_frame, 0);
        tick(1'b0, 1'b0);
        check(in_frame == 1, "R8", "edge 3", in_frame, 1);

        // R10: envelope carrier
        cur_req = "R10";
        restart_with(2'b00, 1, 0);
        tick(1'b0, 1'b0);
        tick(1'b1, 1'b1);
        tick(1'b1, 1'b1);
        tick(1'b0, 1'b1);
        tick(1'b1, 1'b0);
        check(in_frame == 0 && out_valid == 0, "R10", "carrier loss ends frame",
              {in_frame, out_valid}, 0);
        tick(1'b1, 1'b1);
        check(in_frame == 1, "R10", "new envelope restarts", in_frame, 1);

        // R12: configuration change while in frame
        cur_req = "R12";
        tick(1'b1, 1'b1);
        cd_envelope = 0;
        tick(1'b1, 1'b1);
        check(in_frame == 0 && out_valid == 0, "R12", "mode change restarts",
              {in_frame, out_valid}, 0);
        tick(1'b1, 1'b1);
        check(in_frame == 1, "R12", "pulse start after change", in_frame, 1);

        // R11: enable drop
        cur_req = "R11";
        tick(1'b1, 1'b0);
        enable = 0;
        tick(1'b1, 1'b1);
        check(in_frame == 0 && out_valid == 0, "R11", "enable drop", {in_frame, out_valid}, 0);
        tick(1'b1, 1'b1);
        check(in_frame == 0, "R11", "stays in hunt while disabled", in_frame, 0);
        enable = 1;

        // R6: mixed random traffic compared with the model every edge
        cur_req = "R6";
        for (int n = 0; n < 400; n++) begin
            if (n % 50 == 0) begin
                sync_len    = 2'($urandom_range(0, 3));
                cd_envelope = 1'($urandom_range(0, 1));
                cd_async    = 1'($urandom_range(0, 1));
            end
            enable = (n % 97) != 3;
            tick(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule